// File: doc/BRIEF.md
# Byte-Addressed Parity Memory with Alignment Trap

This block is a small synchronous data memory addressed in 8-bit cells. A single request can move one, two, four or eight bytes. Each stored byte has a ninth bit beside it that holds its parity. A requester drives a valid strobe with an address, a size code, a write flag, write data, a byte-order select and a parity-mode select. One clock later the block returns a response strobe with read data and two flags.

Every access must sit on a multiple of its own size. When it does not, the block refuses it. Memory stays untouched and the response carries a fault flag. The byte-order select decides which end of the data bus maps to the lowest address. Multi-byte values can therefore be stored and fetched in either convention over the same cells.

Parity is generated on each write and recomputed on each read. A mismatch raises a flag next to otherwise normal read data. A test-only input stores inverted parity on a write, so that a bench can reach the error path in either parity mode.

Top module: `bytemem_align`

## Requirements
- R1: Each address names one 8-bit cell, and adjacent addresses name adjacent cells. A byte read returns the cell in rsp_rdata[7:0] with all higher bits zero.
- R2: The size code maps as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. rsp_valid is high exactly in the cycle after a cycle with req_valid high, and it is low after reset.
- R3: A request whose address is not a multiple of its byte count sets rsp_fault in its response cycle only. Byte accesses never fault. A word needs address bits [1:0] at zero, and a doubleword needs bits [2:0] at zero.
- R4: A misaligned write changes no cell.
- R5: A misaligned read returns rsp_rdata of zero with rsp_perr low.
- R6: With req_big low, the byte at the access address is the least significant byte of the value, and higher addresses hold more significant bytes.
- R7: With req_big high, the byte at the access address is the most significant byte. Cells 4D 49 50 53 at ascending addresses read as the word 0x4D495053 in this mode and as 0x5350494D with req_big low.
- R8: With par_odd low, each stored byte plus its parity bit holds an even count of ones. With par_odd high, the count is odd. A read of bytes written under the same mode reports rsp_perr low.
- R9: A write with inj_flip high stores inverted parity for every byte it writes. A later aligned read touching any such byte raises rsp_perr, and the data is still returned correctly. Bytes not touched by the read do not raise the flag.
- R10: A write response carries rsp_rdata of zero and rsp_perr low.
- R11: A read issued in the cycle right after a write to the same cells returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the response registers |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | AW | Byte address, AW = log2(DEPTH) |
| req_size | input | 2 | Access size code (R2) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write value, right-justified |
| req_big | input | 1 | 1 = big-endian, 0 = little-endian byte order |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| inj_flip | input | 1 | Test only: store inverted parity on this write |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read value, right-justified and zero-extended |
| rsp_fault | output | 1 | Alignment fault on this response |
| rsp_perr | output | 1 | Parity mismatch among the bytes read |

## Verification
Every result of this block, whether read data, fault or parity flag, is registered at the clock edge that accepts the request. All results are therefore due exactly one cycle after the stimulus. The bench drives each request at a falling edge and pushes its expected response into a queue. A monitor samples rsp_valid at every later falling edge and pops one entry per response. As a result, a response that is late, early, missing or extra is reported as a mismatch. A misaligned write is judged by reading the same cells again through the normal port.

// File: rtl/bytemem_align.sv
module bytemem_align #(
  parameter int DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [$clog2(DEPTH)-1:0]   req_addr,
  input  logic [1:0]                 req_size,
  input  logic                       req_we,
  input  logic [63:0]                req_wdata,
  input  logic                       req_big,
  input  logic                       par_odd,
  input  logic                       inj_flip,
  output logic                       rsp_valid,
  output logic [63:0]                rsp_rdata,
  output logic                       rsp_fault,
  output logic                       rsp_perr
);
  localparam int LANES = 8;
  localparam int AW    = $clog2(DEPTH);
  localparam int ROWS  = DEPTH / LANES;
  localparam int RW    = AW - 3;

  logic [8:0] mem [ROWS][LANES];

  logic [RW-1:0] row;
  logic [3:0]    nbytes;
  logic          misal, do_wr, do_rd;

  assign row    = req_addr[AW-1:3];
  assign nbytes = 4'd1 << req_size;
  assign misal  = (req_addr[2:0] & (nbytes[2:0] - 3'd1)) != 3'd0;
  assign do_wr  = req_valid && req_we && !misal;
  assign do_rd  = req_valid && !req_we && !misal;

  logic [LANES-1:0] lane_on;
  logic [2:0]       lane_idx [LANES];
  logic [7:0]       lane_wd  [LANES];

  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      automatic int k = j - int'(req_addr[2:0]);
      lane_on[j]  = (k >= 0) && (k < int'(nbytes));
      lane_idx[j] = 3'(req_big ? int'(nbytes) - 1 - k : k);
      lane_wd[j]  = req_wdata[8*lane_idx[j] +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr)
      for (int j = 0; j < LANES; j++)
        if (lane_on[j])
          mem[row][j] <= {(^lane_wd[j]) ^ par_odd ^ inj_flip, lane_wd[j]};
  end

  logic [63:0] rd_next;
  logic        perr_next;

  always_comb begin
    rd_next   = '0;
    perr_next = 1'b0;
    for (int j = 0; j < LANES; j++) begin
      if (lane_on[j]) begin
        rd_next[8*lane_idx[j] +: 8] = mem[row][j][7:0];
        if ((^mem[row][j]) != par_odd) perr_next = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_perr  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && misal;
      rsp_perr  <= do_rd && perr_next;
      rsp_rdata <= do_rd ? rd_next : '0;
    end
  end
endmodule

module bytemem_align_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_we,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_fault,
  input logic          rsp_perr,
  input logic [63:0]   rsp_rdata
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd2 && req_addr[1:0] != 2'd0) |=> rsp_fault); // R3
  AST_DWORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd3 && req_addr[2:0] != 3'd0) |=> rsp_fault); // R3
  AST_BYTE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size == 2'd0) |=> !rsp_fault); // R3
  AST_FAULT_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid); // R3
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_rdata == 64'd0 && !rsp_perr)); // R5
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> (rsp_rdata == 64'd0 && !rsp_perr)); // R10
endmodule

bind bytemem_align bytemem_align_chk #(.AW($clog2(DEPTH))) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_fault(rsp_fault), .rsp_perr(rsp_perr), .rsp_rdata(rsp_rdata)
);

// File: tb/bytemem_align_tb.sv
module bytemem_align_tb_top;
  localparam int DEPTH = 64;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic          req_we = 1'b0;
  logic [63:0]   req_wdata = '0;
  logic          req_big = 1'b0;
  logic          par_odd = 1'b0;
  logic          inj_flip = 1'b0;
  logic          rsp_valid, rsp_fault, rsp_perr;
  logic [63:0]   rsp_rdata;

  always #4 clk = ~clk;

  bytemem_align #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_we(req_we), .req_wdata(req_wdata),
    .req_big(req_big), .par_odd(par_odd), .inj_flip(inj_flip),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .rsp_perr(rsp_perr)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [7:0]  ref_mem [DEPTH];
  bit          ref_bad [DEPTH];
  logic [65:0] exp_q [$];
  string       tag_q [$];

  task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got fault=%b perr=%b data=%h exp fault=%b perr=%b data=%h",
               tag, got[65], got[64], got[63:0], exp[65], exp[64], exp[63:0]);
    end
  endtask

  task automatic issue(input bit we, input int size, input int addr, input logic [63:0] wd,
                       input bit big, input bit inj, input string tag);
    int nb;
    bit mis, perr;
    logic [63:0] rd;
    nb = 1 << size;
    mis = (addr % nb) != 0;
    rd = '0;
    perr = 0;
    if (!mis) begin
      for (int k = 0; k < nb; k++) begin
        int idx;
        idx = big ? nb - 1 - k : k;
        if (we) begin
          ref_mem[addr+k] = wd[8*idx +: 8];
          ref_bad[addr+k] = inj;
        end else begin
          rd[8*idx +: 8] = ref_mem[addr+k];
          perr |= ref_bad[addr+k];
        end
      end
    end
    req_valid = 1'b1;
    req_we    = we;
    req_size  = 2'(size);
    req_addr  = AW'(addr);
    req_wdata = wd;
    req_big   = big;
    inj_flip  = inj;
    exp_q.push_back({mis, perr, rd});
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    inj_flip  = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) check("R2 extra response", {rsp_fault, rsp_perr, rsp_rdata}, 66'h3_FFFF_FFFF_FFFF_FFFF);
        else check(tag_q.pop_front(), {rsp_fault, rsp_perr, rsp_rdata}, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset state", {rsp_fault, rsp_perr, rsp_rdata}, 66'd0);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++;
      $display("FAIL R2 reset valid: got %b exp 0", rsp_valid);
    end

    par_odd = 1'b0;
    issue(1, 0, 0, 64'h4D, 0, 0, "R10 byte write");
    issue(1, 0, 1, 64'h49, 0, 0, "R10 byte write");
    issue(1, 0, 2, 64'h50, 1, 0, "R10 byte write");
    issue(1, 0, 3, 64'h53, 1, 0, "R10 byte write");
    issue(0, 2, 0, 64'd0, 0, 0, "R6 little word");
    issue(0, 2, 0, 64'd0, 1, 0, "R7 big word");
    issue(0, 1, 2, 64'd0, 1, 0, "R7 big half");
    issue(0, 0, 1, 64'd0, 0, 0, "R1 byte read");
    issue(0, 0, 3, 64'd0, 1, 0, "R1 byte read");

    issue(1, 3, 8, 64'h1122334455667788, 0, 0, "R10 dword write");
    issue(0, 3, 8, 64'd0, 1, 0, "R7 big dword");
    issue(0, 2, 12, 64'd0, 0, 0, "R6 little word upper");
    issue(0, 1, 8, 64'd0, 0, 0, "R6 little half");
    issue(0, 2, 12, 64'd0, 1, 0, "R3 aligned C no fault");

    issue(0, 2, 3, 64'd0, 0, 0, "R5 misaligned word read");
    issue(1, 1, 1, 64'hFFFF, 0, 0, "R3 misaligned half write");
    issue(0, 2, 0, 64'd0, 1, 0, "R4 cells unchanged");
    issue(1, 3, 4, 64'hDEADBEEFDEADBEEF, 0, 0, "R3 misaligned dword write");
    issue(0, 3, 8, 64'd0, 0, 0, "R4 dword cells unchanged");
    issue(0, 3, 12, 64'd0, 0, 0, "R5 misaligned dword read");
    issue(0, 1, 7, 64'd0, 1, 0, "R3 misaligned half read");

    issue(1, 2, 16, 64'hCAFEF00D, 1, 0, "R10 word write");
    issue(0, 2, 16, 64'd0, 1, 0, "R11 read after write");
    issue(0, 0, 16, 64'd0, 0, 0, "R7 big first byte");
    idle(2);

    par_odd = 1'b1;
    @(negedge clk);
    issue(1, 2, 24, 64'h00FF0F01, 0, 0, "R10 odd-mode write");
    issue(0, 2, 24, 64'd0, 0, 0, "R8 odd parity clean");
    issue(1, 0, 25, 64'hA5, 0, 1, "R10 injected write");
    issue(0, 2, 24, 64'd0, 0, 0, "R9 odd parity error");
    issue(0, 0, 26, 64'd0, 0, 0, "R9 untouched byte clean");
    idle(2);

    par_odd = 1'b0;
    @(negedge clk);
    issue(1, 2, 32, 64'h13572468, 1, 0, "R10 even-mode write");
    issue(0, 2, 32, 64'd0, 1, 0, "R8 even parity clean");
    issue(1, 0, 35, 64'h3C, 0, 1, "R10 injected write");
    issue(0, 0, 35, 64'd0, 0, 0, "R9 even parity error");
    issue(0, 0, 34, 64'd0, 0, 0, "R9 neighbour clean");
    issue(0, 3, 32, 64'd0, 0, 0, "R9 dword covers error");
    idle(4);

    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2 missing responses: got %0d pending exp 0", exp_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule